// File: doc/BRIEF.md
# Timer Interrupt-Clear and Interval Reload Slice

This block is the part of a two-half general-purpose timer's register map that tracks interrupt status and holds the interval reload values. Seven status bits are kept: one RTC bit, and for each half a timeout bit, a capture-match bit and a capture-event bit. Pulses from the counters and the capture logic set these bits, and software clears them by writing ones to a write-one-to-clear register. A mask input selects which status bits reach the single interrupt line. There is no separate masked copy to clear, because the masked view is derived from the raw bits.

The two reload registers feed the counter halves. A configuration input picks between two split 16-bit timers and one joined 32-bit timer. When the timer is joined, the upper half of the A reload register is the B reload register itself. A write to A then loads both halves, and direct writes to B are dropped. When the timer is split, each register keeps 16 bits and its upper half reads as zero. Every accepted reload write raises a one-cycle load strobe toward each counter half whose value it changed.

The bus is a simple synchronous one. A write is taken on the clock edge while the write enable is high. Read data follows the address combinationally.

Top module: `tmr_intclr_reload`

## Requirements
- R1: After reset, all seven raw status bits are 0, both stored reload halves are 0xFFFF, and both load strobes are low. A read of the A reload returns 0x0000FFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R2: A write to offset 0x024 clears raw status bits selected by ones in the write data, one cycle later. Data bit 0 clears status 0 (A timeout), bit 1 clears status 1 (A capture match), bit 2 clears status 2 (A capture event), bit 3 clears status 3 (RTC), bit 8 clears status 4 (B timeout), bit 9 clears status 5 (B capture match) and bit 10 clears status 6 (B capture event). Zero bits leave their status unchanged.
- R3: A high on event input bit i sets raw status bit i in the next cycle. The bit then holds until it is cleared.
- R4: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The masked status is the raw status ANDed with the mask input. The interrupt output is high exactly when any masked bit is set.
- R6: Offset 0x024 always reads as zero. Ones written to its reserved bits (31:11 and 7:4) change no status bit.
- R7: In 32-bit mode (cfg_wide=1), a write to offset 0x028 stores data bits 15:0 as the A half and data bits 31:16 as the B reload. A read of 0x028 returns {B reload, A half}.
- R8: In 16-bit mode, a read of 0x028 returns zero in bits 31:16. A write to 0x028 leaves the B reload unchanged.
- R9: In 32-bit mode, a write to offset 0x02C changes nothing and raises no strobe. A read of 0x02C returns the current B reload value in bits 15:0.
- R10: In 16-bit mode, a write to offset 0x02C stores data bits 15:0 as the B reload. A read of 0x02C returns zero in bits 31:16 in both modes.
- R11: A write to 0x028 pulses ld_a_stb for one cycle. ld_b_stb pulses for one cycle after a 16-bit-mode write to 0x02C or a 32-bit-mode write to 0x028. Both strobes rise in the cycle where the new value first appears on the reload outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 = halves joined as one 32-bit timer, 0 = two 16-bit timers |
| bus_we | input | 1 | Write enable, taken on the clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| evt_set | input | 7 | Set pulses: 0 A timeout, 1 A match, 2 A event, 3 RTC, 4 B timeout, 5 B match, 6 B event |
| irq_mask | input | 7 | Per-bit interrupt enable |
| irq_raw | output | 7 | Raw status |
| irq_masked | output | 7 | Raw status ANDed with mask |
| irq_out | output | 1 | OR of the masked status |
| rld_a | output | DATA_W | Reload value for the A counter, as read at 0x028 |
| rld_b | output | HALF_W | Reload value for the B counter |
| ld_a_stb | output | 1 | One-cycle load pulse for the A counter |
| ld_b_stb | output | 1 | One-cycle load pulse for the B counter |

## Verification
The bench targets the gap between clear-bit positions and status indices. It clears each half separately, so a design that maps bits 8 to 10 onto status 4 to 6 wrongly would leave B bits set or wipe the A bits. A write of ones to only the reserved positions must change nothing; a design that decodes them would drop status. An event and a clear aimed at the same bit in the same cycle must leave the bit set; a clear-first design would lose the event. The mode aliasing is checked from both sides: the B value must not move on a 16-bit A write or on a 32-bit B write, and a read of A in 32-bit mode must show the B value in its upper half. The strobes are checked for width and for which half they name, so a level strobe or a strobe on a dropped write would show.

// File: rtl/tmr_icr_pkg.sv
`timescale 1ns/1ps
package tmr_icr_pkg;

    // number of interrupt status bits held by the slice
    localparam int unsigned NUM_IRQ = 7;

    // register byte offsets (decoded by the neighbouring bus fabric)
    localparam int unsigned OFF_ICR  = 32'h024;
    localparam int unsigned OFF_RLDA = 32'h028;
    localparam int unsigned OFF_RLDB = 32'h02C;

    // bit position in the clear register for each status index
    localparam int unsigned CLR_POS [NUM_IRQ] = '{0, 1, 2, 3, 8, 9, 10};

    // gather the clear-register bits into status-index order
    function automatic logic [NUM_IRQ-1:0] icr_to_irq(input logic [31:0] w);
        logic [NUM_IRQ-1:0] m;
        for (int k = 0; k < NUM_IRQ; k++) begin
            m[k] = w[CLR_POS[k]];
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_irq_status.sv
`timescale 1ns/1ps
module tmr_irq_status #(
    parameter int NUM_IRQ = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    input  logic [NUM_IRQ-1:0] mask_i,
    output logic [NUM_IRQ-1:0] raw_o,
    output logic [NUM_IRQ-1:0] masked_o,
    output logic               any_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] raw;
    } st_t;

    st_t st_d, st_q;

    // clear first, then set: a same-cycle event survives
    always_comb begin
        st_d     = st_q;
        st_d.raw = (st_q.raw & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.raw;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_mask
        assign masked_o[g] = st_q.raw[g] & mask_i[g];
    end

    assign any_o = |masked_o;

endmodule

// File: rtl/tmr_reload_regs.sv
`timescale 1ns/1ps
module tmr_reload_regs #(
    parameter  int HALF_W = 16,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              wr_a_i,
    input  logic              wr_b_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [HALF_W-1:0] a_lo_o,
    output logic [HALF_W-1:0] b_o,
    output logic              ld_a_o,
    output logic              ld_b_o
);

    typedef struct packed {
        logic [HALF_W-1:0] a_lo;
        logic [HALF_W-1:0] b;
        logic              ld_a;
        logic              ld_b;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ld_a = 1'b0;
        st_d.ld_b = 1'b0;
        if (wr_a_i) begin
            st_d.a_lo = wdata_i[HALF_W-1:0];
            st_d.ld_a = 1'b1;
            if (wide_i) begin
                // joined mode: upper half of A is the B storage
                st_d.b    = wdata_i[DATA_W-1:HALF_W];
                st_d.ld_b = 1'b1;
            end
        end
        if (wr_b_i && !wide_i) begin
            st_d.b    = wdata_i[HALF_W-1:0];
            st_d.ld_b = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.a_lo <= '1;
            st_q.b    <= '1;
            st_q.ld_a <= 1'b0;
            st_q.ld_b <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_lo_o = st_q.a_lo;
    assign b_o    = st_q.b;
    assign ld_a_o = st_q.ld_a;
    assign ld_b_o = st_q.ld_b;

endmodule

// File: rtl/tmr_intclr_reload.sv
`timescale 1ns/1ps
module tmr_intclr_reload
    import tmr_icr_pkg::*;
#(
    parameter  int ADDR_W = 12,
    parameter  int HALF_W = 16,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wide,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_IRQ-1:0] evt_set,
    input  logic [NUM_IRQ-1:0] irq_mask,
    output logic [NUM_IRQ-1:0] irq_raw,
    output logic [NUM_IRQ-1:0] irq_masked,
    output logic               irq_out,
    output logic [DATA_W-1:0]  rld_a,
    output logic [HALF_W-1:0]  rld_b,
    output logic               ld_a_stb,
    output logic               ld_b_stb
);

    localparam logic [ADDR_W-1:0] A_ICR  = ADDR_W'(OFF_ICR);
    localparam logic [ADDR_W-1:0] A_RLDA = ADDR_W'(OFF_RLDA);
    localparam logic [ADDR_W-1:0] A_RLDB = ADDR_W'(OFF_RLDB);

    logic               hit_icr, hit_a, hit_b;
    logic [NUM_IRQ-1:0] clr_vec;
    logic [HALF_W-1:0]  a_lo, b_val;
    logic [DATA_W-1:0]  a_view, b_view;

    assign hit_icr = (bus_addr == A_ICR);
    assign hit_a   = (bus_addr == A_RLDA);
    assign hit_b   = (bus_addr == A_RLDB);

    assign clr_vec = (bus_we && hit_icr) ? icr_to_irq(32'(bus_wdata)) : '0;

    tmr_irq_status #(
        .NUM_IRQ (NUM_IRQ)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_set),
        .clr_i    (clr_vec),
        .mask_i   (irq_mask),
        .raw_o    (irq_raw),
        .masked_o (irq_masked),
        .any_o    (irq_out)
    );

    tmr_reload_regs #(
        .HALF_W (HALF_W)
    ) u_reload (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide_i  (cfg_wide),
        .wr_a_i  (bus_we && hit_a),
        .wr_b_i  (bus_we && hit_b),
        .wdata_i (bus_wdata),
        .a_lo_o  (a_lo),
        .b_o     (b_val),
        .ld_a_o  (ld_a_stb),
        .ld_b_o  (ld_b_stb)
    );

    // register views as the bus sees them
    assign a_view = cfg_wide ? {b_val, a_lo} : {{HALF_W{1'b0}}, a_lo};
    assign b_view = {{HALF_W{1'b0}}, b_val};

    always_comb begin
        bus_rdata = '0;
        if (hit_a) begin
            bus_rdata = a_view;
        end else if (hit_b) begin
            bus_rdata = b_view;
        end
    end

    assign rld_a = a_view;
    assign rld_b = b_val;

endmodule

// File: rtl/tmr_intclr_reload_chk.sv
`timescale 1ns/1ps
module tmr_intclr_reload_chk
    import tmr_icr_pkg::*;
#(
    parameter  int ADDR_W = 12,
    parameter  int HALF_W = 16,
    localparam int DATA_W = 2 * HALF_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wide,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_IRQ-1:0] evt_set,
    input logic [NUM_IRQ-1:0] irq_raw,
    input logic [HALF_W-1:0]  rld_b,
    input logic               ld_a_stb,
    input logic               ld_b_stb
);

    logic [NUM_IRQ-1:0] chk_clr;
    logic               wr_icr, wr_a, wr_b;

    assign chk_clr = icr_to_irq(32'(bus_wdata));
    assign wr_icr  = bus_we && (bus_addr == ADDR_W'(OFF_ICR));
    assign wr_a    = bus_we && (bus_addr == ADDR_W'(OFF_RLDA));
    assign wr_b    = bus_we && (bus_addr == ADDR_W'(OFF_RLDB));

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_icr |=> ((irq_raw & $past(chk_clr & ~evt_set)) == '0));

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((irq_raw & $past(evt_set)) == $past(evt_set)));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_icr && |(chk_clr & evt_set)) |=>
        ((irq_raw & $past(chk_clr & evt_set)) == $past(chk_clr & evt_set)));

    assert_icr_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_ICR)) |-> (bus_rdata == '0));

    assert_b_kept_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && !cfg_wide) |=> $stable(rld_b));

    assert_b_locked_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && cfg_wide) |=> ($stable(rld_b) && !ld_b_stb));

    assert_b_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_RLDB)) |-> (bus_rdata[DATA_W-1:HALF_W] == '0));

    assert_lda_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> ld_a_stb);

    assert_strobe_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a_stb || ld_b_stb) |-> $past(bus_we));

endmodule

bind tmr_intclr_reload tmr_intclr_reload_chk #(
    .ADDR_W (ADDR_W),
    .HALF_W (HALF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wide  (cfg_wide),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_set   (evt_set),
    .irq_raw   (irq_raw),
    .rld_b     (rld_b),
    .ld_a_stb  (ld_a_stb),
    .ld_b_stb  (ld_b_stb)
);

// File: tb/test_tmr_intclr_reload.sv
`timescale 1ns/1ps
module test_tmr_intclr_reload;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wide;
    logic        bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [6:0]  evt_set;
    logic [6:0]  irq_mask;
    logic [6:0]  irq_raw;
    logic [6:0]  irq_masked;
    logic        irq_out;
    logic [31:0] rld_a;
    logic [15:0] rld_b;
    logic        ld_a_stb;
    logic        ld_b_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    tmr_intclr_reload i_tmr_intclr_reload (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wide   (cfg_wide),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_set    (evt_set),
        .irq_mask   (irq_mask),
        .irq_raw    (irq_raw),
        .irq_masked (irq_masked),
        .irq_out    (irq_out),
        .rld_a      (rld_a),
        .rld_b      (rld_b),
        .ld_a_stb   (ld_a_stb),
        .ld_b_stb   (ld_b_stb)
    );

    // row: mode, we, addr, wdata, evt, mask, exp_rdata, exp_raw, exp_irq, exp_lda, exp_ldb
    localparam int NV = 16;
    localparam logic [101:0] TBL [NV] = '{
        {1'b0, 1'b0, 12'h024, 32'h00000000, 7'h7F, 7'h7F, 32'h00000000, 7'h7F, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 12'h024, 32'h00000005, 7'h00, 7'h7F, 32'h00000000, 7'h7A, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 12'h024, 32'h00000700, 7'h00, 7'h7F, 32'h00000000, 7'h0A, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 12'h024, 32'hFFFFF0F0, 7'h00, 7'h7F, 32'h00000000, 7'h0A, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 12'h024, 32'h00000000, 7'h00, 7'h01, 32'h00000000, 7'h0A, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 12'h024, 32'h00000000, 7'h00, 7'h08, 32'h00000000, 7'h0A, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 12'h024, 32'h00000008, 7'h08, 7'h08, 32'h00000000, 7'h0A, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 12'h024, 32'h0000000A, 7'h00, 7'h7F, 32'h00000000, 7'h00, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 12'h028, 32'hABCD1234, 7'h00, 7'h7F, 32'h00001234, 7'h00, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b0, 12'h02C, 32'h00000000, 7'h00, 7'h7F, 32'h0000FFFF, 7'h00, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 12'h02C, 32'hDEAD5678, 7'h00, 7'h7F, 32'h00005678, 7'h00, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b0, 12'h028, 32'h00000000, 7'h00, 7'h7F, 32'h56781234, 7'h00, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 12'h028, 32'h9ABC4321, 7'h00, 7'h7F, 32'h9ABC4321, 7'h00, 1'b0, 1'b1, 1'b1},
        {1'b1, 1'b0, 12'h02C, 32'h00000000, 7'h00, 7'h7F, 32'h00009ABC, 7'h00, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 12'h02C, 32'h00001111, 7'h00, 7'h7F, 32'h00009ABC, 7'h00, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 12'h028, 32'h00000000, 7'h00, 7'h7F, 32'h00004321, 7'h00, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    // drive for one cycle, then sample after the edge with address held
    task automatic cycle(input logic mode, input logic we, input logic [11:0] addr,
                         input logic [31:0] wd, input logic [6:0] evt,
                         input logic [6:0] mask);
        @(negedge clk);
        cfg_wide  = mode;
        bus_we    = we;
        bus_addr  = addr;
        bus_wdata = wd;
        evt_set   = evt;
        irq_mask  = mask;
        @(negedge clk);
        bus_we  = 1'b0;
        evt_set = '0;
        #1;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before the run ended");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        cfg_wide  = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = 12'h028;
        bus_wdata = '0;
        evt_set   = '0;
        irq_mask  = 7'h7F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state
        check("R1", "raw after reset", 32'(irq_raw), 32'h0);
        check("R1", "irq after reset", 32'(irq_out), 32'h0);
        check("R1", "ld_a after reset", 32'(ld_a_stb), 32'h0);
        check("R1", "ld_b after reset", 32'(ld_b_stb), 32'h0);
        check("R1", "A read 16-bit", bus_rdata, 32'h0000FFFF);
        cfg_wide = 1'b1;
        #1;
        check("R1", "A read 32-bit", bus_rdata, 32'hFFFFFFFF);
        check("R1", "rld_a 32-bit", rld_a, 32'hFFFFFFFF);
        cfg_wide = 1'b0;
        bus_addr = 12'h02C;
        #1;
        check("R1", "B read", bus_rdata, 32'h0000FFFF);

        // R4 on the B half: event on B timeout with a clear of bit 8
        cycle(1'b0, 1'b1, 12'h024, 32'h00000100, 7'h10, 7'h7F);
        check("R4", "B timeout survives clear", 32'(irq_raw), 32'h10);
        check("R5", "masked B timeout", 32'(irq_masked), 32'h10);
        cycle(1'b0, 1'b1, 12'h024, 32'h00000100, 7'h00, 7'h7F);
        check("R2", "B timeout cleared by bit 8", 32'(irq_raw), 32'h0);

        // R11: strobe width, R8: B untouched by a 16-bit A write
        cycle(1'b0, 1'b1, 12'h028, 32'h77770001, 7'h00, 7'h7F);
        check("R11", "ld_a pulse", 32'(ld_a_stb), 32'h1);
        check("R11", "no ld_b on 16-bit A write", 32'(ld_b_stb), 32'h0);
        check("R8", "B kept", 32'(rld_b), 32'hFFFF);
        check("R8", "A upper zero", bus_rdata, 32'h00000001);
        cycle(1'b0, 1'b0, 12'h028, 32'h0, 7'h00, 7'h7F);
        check("R11", "ld_a drops after one cycle", 32'(ld_a_stb), 32'h0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            logic [101:0] v;
            v = TBL[i];
            cycle(v[101], v[100], v[99:88], v[87:56], v[55:49], v[48:42]);
            check("R2/R3/R4/R6 raw", $sformatf("row %0d raw", i), 32'(irq_raw), 32'(v[9:3]));
            check("R5", $sformatf("row %0d irq", i), 32'(irq_out), 32'(v[2]));
            check("R5", $sformatf("row %0d masked", i), 32'(irq_masked), 32'(v[9:3] & v[48:42]));
            check("R6/R7/R8/R9/R10 read", $sformatf("row %0d rdata", i), bus_rdata, v[41:10]);
            check("R11", $sformatf("row %0d ld_a", i), 32'(ld_a_stb), 32'(v[1]));
            check("R11", $sformatf("row %0d ld_b", i), 32'(ld_b_stb), 32'(v[0]));
        end

        // R7: counter-facing outputs after the joined-mode write
        cfg_wide = 1'b1;
        #1;
        check("R7", "rld_a joined", rld_a, 32'h9ABC4321);
        check("R7", "rld_b joined", 32'(rld_b), 32'h9ABC);
        // R9: dropped wide write leaves B and raises no strobe
        cycle(1'b1, 1'b1, 12'h02C, 32'h00002222, 7'h00, 7'h7F);
        check("R9", "B unchanged", 32'(rld_b), 32'h9ABC);
        check("R9", "no ld_b", 32'(ld_b_stb), 32'h0);
        // R10: 16-bit B write reaches the counter output
        cycle(1'b0, 1'b1, 12'h02C, 32'hFFFF3333, 7'h00, 7'h7F);
        check("R10", "rld_b narrow", 32'(rld_b), 32'h3333);
        check("R10", "B upper zero", bus_rdata, 32'h00003333);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule